// File: doc/BRIEF.md
# Confidence-Steered Speculative Fill Buffer

This unit sits beside a first-level cache. It decides where each incoming miss line is placed, and it runs a small side store that the core probes in parallel with the main cache. A miss line comes in on the fill port with a one-bit confidence tag. The core derives that tag from its speculation state combined with the current branch-prediction estimate.

Lines that are probably on the correct path go to the main cache. Lines that are probably from a mis-speculated path go to the side store. This keeps wrong-path lines from pushing useful lines out of the main cache.

A second placement mode ignores confidence. In that mode a pseudo-random generator sends a programmable fraction of fills, in steps of 1/256, to the side store. A lookup that hits in the side store returns its line, so the core treats it as a cache hit. The side store is fully associative with least-recently-used replacement by default. A parameter selects a direct-mapped variant instead.

Top module: `spec_fill_buf`

## Requirements
- R1: After reset every side-store entry is invalid, all registered outputs are low, and the random generator holds 8'h01.
- R2: With `cfg_mode`=0 and `fill_conf`=1 (high confidence), one cycle after the fill `mfill_valid` is 1 with the fill's address and data, `bfill_taken` is 0, and the side store is not written.
- R3: With `cfg_mode`=0 and `fill_conf`=0 (low confidence), one cycle after the fill `bfill_taken` is 1, `mfill_valid` is 0, and the line is written into the side store.
- R4: With `cfg_mode`=1, `fill_conf` has no effect. A fill goes to the side store exactly when the current 8-bit generator value is below `cfg_frac`, so `cfg_frac`=0 sends every fill to the main cache. The generator advances once per fill, and only in this mode. Its next value is {s[6:0], s[7]^s[5]^s[4]^s[3]}.
- R5: A lookup gets a response one cycle later: `rsp_valid`=1, `rsp_hit` tells whether the address is held in the side store, and `rsp_data` carries the stored line on a hit and zero on a miss.
- R6: A side-store fill whose address is already held overwrites that entry's data in place, so at most one entry ever holds a given address.
- R7: A main-cache fill whose address is held in the side store invalidates that copy.
- R8: A side-store fill of a new address takes an invalid entry if one exists. Otherwise it evicts the least recently used entry. Both lookup hits and side-store writes count as uses, and when both happen in the same cycle only the write counts.
- R9: A lookup issued in the same cycle as a fill sees the side store as it was before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | 0: place by confidence, 1: place at random |
| cfg_frac | input | 8 | Fraction of fills sent to the side store in random mode, in 1/256 steps |
| lkp_valid | input | 1 | Lookup request |
| lkp_addr | input | ADDR_W | Line address looked up |
| fill_valid | input | 1 | Miss line arriving |
| fill_addr | input | ADDR_W | Line address of the fill |
| fill_data | input | DATA_W | Line data of the fill |
| fill_conf | input | 1 | 1: high confidence (correct path), 0: low confidence |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit in the side store |
| rsp_data | output | DATA_W | Line data on a hit, zero on a miss |
| mfill_valid | output | 1 | Line to be written into the main cache |
| mfill_addr | output | ADDR_W | Address of the main-cache line |
| mfill_data | output | DATA_W | Data of the main-cache line |
| bfill_taken | output | 1 | Fill was placed in the side store |

## Verification
The bench aims at these corner cases, and each one shows a typical design error:
- **Refilling a held address.** A design that allocated a second entry would lose capacity, and the sixteenth distinct address would evict a line too early.
- **Eviction after touching the oldest line.** A design that ignored lookup hits as uses would evict the line just touched.
- **High-confidence fill of a buffered address.** A design that did not invalidate the buffered copy would keep serving stale data.
- **Lookup colliding with a fill.** A design that forwarded the fill would report a premature hit.
- **Random placement at fractions 0, 255 and in between, with confidence varied.** A design with a wrong comparison, a wrong generator step, or a leak of the confidence bit would place lines differently from the bench's own generator.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam int RND_W = 8;

  typedef enum logic {
    PLACE_CONF = 1'b0,
    PLACE_RAND = 1'b1
  } place_mode_e;

  // one step of the 8-bit placement generator
  function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  // placement decision: 1 means the side store takes the line
  function automatic logic goes_to_side(input logic mode, input logic conf,
                                        input logic [RND_W-1:0] rnd,
                                        input logic [RND_W-1:0] frac);
    if (mode == PLACE_RAND) return rnd < frac;
    return !conf;
  endfunction
endpackage

// File: rtl/sfb_steer.sv
module sfb_steer
  import sfb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_valid,
  input  logic             fill_conf,
  input  logic             cfg_mode,
  input  logic [RND_W-1:0] cfg_frac,
  output logic             to_side
);
  logic [RND_W-1:0] rnd_q;
  logic             rnd_adv;

  assign rnd_adv = fill_valid && (cfg_mode == PLACE_RAND);
  assign to_side = goes_to_side(cfg_mode, fill_conf, rnd_q, cfg_frac);

  always_ff @(posedge clk) begin
    if (!rst_n)       rnd_q <= RND_W'(1);
    else if (rnd_adv) rnd_q <= rnd_step(rnd_q);
  end

  // R4
  rnd_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_q != '0);

  // R4
  rnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rnd_adv |=> $stable(rnd_q));
endmodule

// File: rtl/sfb_store.sv
module sfb_store #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int ENTRIES     = 16,
  parameter bit FULLY_ASSOC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [ADDR_W-1:0] lkp_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              to_side,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] val_q;
  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [DATA_W-1:0]  dat_q [ENTRIES];

  logic [ENTRIES-1:0] lk_match, fl_match;
  logic [IDX_W-1:0]   lk_slot, fl_slot, victim, wslot, tslot;
  logic               fl_hit, side_write, main_clear, touch;

  // match vectors; the direct-mapped variant only compares the indexed slot
  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    logic lk_sel, fl_sel;
    if (FULLY_ASSOC) begin : g_fa
      assign lk_sel = 1'b1;
      assign fl_sel = 1'b1;
    end else begin : g_dm
      assign lk_sel = (lkp_addr[IDX_W-1:0] == IDX_W'(i));
      assign fl_sel = (fill_addr[IDX_W-1:0] == IDX_W'(i));
    end
    assign lk_match[i] = lk_sel && val_q[i] && (tag_q[i] == lkp_addr);
    assign fl_match[i] = fl_sel && val_q[i] && (tag_q[i] == fill_addr);
  end

  always_comb begin
    lk_slot = '0;
    fl_slot = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) lk_slot = IDX_W'(i);
      if (fl_match[i]) fl_slot = IDX_W'(i);
    end
  end

  assign lk_hit     = |lk_match;
  assign lk_data    = lk_hit ? dat_q[lk_slot] : '0;
  assign fl_hit     = |fl_match;
  assign side_write = fill_valid && to_side;
  assign main_clear = fill_valid && !to_side && fl_hit;
  assign wslot      = fl_hit ? fl_slot : victim;
  assign touch      = side_write || (lkp_valid && lk_hit);
  assign tslot      = side_write ? wslot : lk_slot;

  if (FULLY_ASSOC) begin : g_lru
    logic [IDX_W-1:0] age_q [ENTRIES];

    always_comb begin
      logic found;
      found  = 1'b0;
      victim = '0;
      for (int i = 0; i < ENTRIES; i++) begin
        if (!found && !val_q[i]) begin
          victim = IDX_W'(i);
          found  = 1'b1;
        end
      end
      if (!found) begin
        for (int i = 0; i < ENTRIES; i++)
          if (age_q[i] == AGE_MAX) victim = IDX_W'(i);
      end
    end

    // ages stay a permutation: the touched entry becomes 0, younger ones age by one
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
      end else if (touch) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == tslot)          age_q[i] <= '0;
          else if (age_q[i] < age_q[tslot]) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end

    // R8
    oldest_exists_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&val_q) |-> (age_q[victim] == AGE_MAX));
  end else begin : g_dm_victim
    assign victim = fill_addr[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (side_write) begin
      val_q[wslot] <= 1'b1;
    end else if (main_clear) begin
      val_q[fl_slot] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (side_write) begin
      tag_q[wslot] <= fill_addr;
      dat_q[wslot] <= fill_data;
    end
  end

  // R6
  lkp_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R6
  fill_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fl_match));

  // R3
  wslot_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    side_write |=> val_q[$past(wslot)]);

  // R7
  clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_clear |=> !val_q[$past(fl_slot)]);
endmodule

// File: rtl/spec_fill_buf.sv
module spec_fill_buf
  import sfb_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int ENTRIES     = 16,
  parameter bit FULLY_ASSOC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic [7:0]        cfg_frac,
  input  logic              lkp_valid,
  input  logic [ADDR_W-1:0] lkp_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_conf,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mfill_valid,
  output logic [ADDR_W-1:0] mfill_addr,
  output logic [DATA_W-1:0] mfill_data,
  output logic              bfill_taken
);
  logic              to_side;
  logic              lk_hit;
  logic [DATA_W-1:0] lk_data;

  sfb_steer u_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_valid (fill_valid),
    .fill_conf  (fill_conf),
    .cfg_mode   (cfg_mode),
    .cfg_frac   (cfg_frac),
    .to_side    (to_side)
  );

  sfb_store #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .ENTRIES     (ENTRIES),
    .FULLY_ASSOC (FULLY_ASSOC)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .lkp_valid  (lkp_valid),
    .lkp_addr   (lkp_addr),
    .fill_valid (fill_valid),
    .fill_addr  (fill_addr),
    .fill_data  (fill_data),
    .to_side    (to_side),
    .lk_hit     (lk_hit),
    .lk_data    (lk_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_data    <= '0;
      mfill_valid <= 1'b0;
      mfill_addr  <= '0;
      mfill_data  <= '0;
      bfill_taken <= 1'b0;
    end else begin
      rsp_valid   <= lkp_valid;
      rsp_hit     <= lkp_valid && lk_hit;
      rsp_data    <= lkp_valid ? lk_data : '0;
      mfill_valid <= fill_valid && !to_side;
      mfill_addr  <= fill_valid ? fill_addr : '0;
      mfill_data  <= fill_valid ? fill_data : '0;
      bfill_taken <= fill_valid && to_side;
    end
  end

  // R2
  high_conf_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && cfg_mode == PLACE_CONF && fill_conf) |=> (mfill_valid && !bfill_taken));

  // R3
  low_conf_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && cfg_mode == PLACE_CONF && !fill_conf) |=> (bfill_taken && !mfill_valid));

  // R4
  zero_frac_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && cfg_mode == PLACE_RAND && cfg_frac == 8'd0) |=> mfill_valid);

  // R5
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> rsp_valid);

  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_data == '0));

  // R2
  one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mfill_valid && bfill_taken));
endmodule

// File: tb/sim_spec_fill_buf.sv
module sim_spec_fill_buf;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NE = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_mode = 1'b0;
  logic [7:0]    cfg_frac = 8'd0;
  logic          lkp_valid = 1'b0;
  logic [AW-1:0] lkp_addr = '0;
  logic          fill_valid = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic          fill_conf = 1'b0;
  logic          rsp_valid, rsp_hit, mfill_valid, bfill_taken;
  logic [DW-1:0] rsp_data, mfill_data;
  logic [AW-1:0] mfill_addr;

  spec_fill_buf u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_frac(cfg_frac),
    .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .fill_conf(fill_conf),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .mfill_valid(mfill_valid), .mfill_addr(mfill_addr), .mfill_data(mfill_data),
    .bfill_taken(bfill_taken)
  );

  always #5 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // reference model: entries with use stamps
  logic [AW-1:0] m_addr [NE];
  logic [DW-1:0] m_data [NE];
  bit            m_val  [NE];
  int            m_stamp[NE];
  int            m_time = 0;
  logic [7:0]    m_rnd = 8'h01;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int m_find(input logic [AW-1:0] a);
    for (int i = 0; i < NE; i++) if (m_val[i] && m_addr[i] == a) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    int best = 0;
    for (int i = 0; i < NE; i++) if (!m_val[i]) return i;
    for (int i = 1; i < NE; i++) if (m_stamp[i] < m_stamp[best]) best = i;
    return best;
  endfunction

  function automatic logic [7:0] m_rnd_next(input logic [7:0] s);
    logic fb = ^(s & 8'b1011_1000);
    return (s << 1) | {7'd0, fb};
  endfunction

  // one cycle of stimulus: drive at negedge, check at the following negedge
  task automatic step(input bit lk, input logic [AW-1:0] la, input bit fl,
                      input logic [AW-1:0] fa, input logic [DW-1:0] fd,
                      input bit cf, input string ltag);
    int li, fi, slot;
    bit exp_side;
    bit exp_hit;
    logic [DW-1:0] exp_d;
    string ftag;
    lkp_valid = lk; lkp_addr = la;
    fill_valid = fl; fill_addr = fa; fill_data = fd; fill_conf = cf;
    li = lk ? m_find(la) : -1;
    exp_hit = (li >= 0);
    exp_d = exp_hit ? m_data[li] : '0;
    if (cfg_mode) begin
      exp_side = fl && (m_rnd < cfg_frac);
      ftag = "R4";
      if (fl) m_rnd = m_rnd_next(m_rnd);
    end else begin
      exp_side = fl && !cf;
      ftag = cf ? "R2" : "R3";
    end
    @(posedge clk);
    m_time++;
    if (fl) begin
      fi = m_find(fa);
      if (exp_side) begin
        slot = (fi >= 0) ? fi : m_victim();
        m_val[slot] = 1'b1; m_addr[slot] = fa; m_data[slot] = fd;
        m_stamp[slot] = m_time;
      end else if (fi >= 0) begin
        m_val[fi] = 1'b0;
      end
    end
    if (exp_hit && !exp_side) m_stamp[li] = m_time;
    @(negedge clk);
    lkp_valid = 1'b0; fill_valid = 1'b0;
    if (lk) begin
      chk(rsp_valid == 1'b1, ltag, "rsp_valid", 64'(rsp_valid), 64'd1);
      chk(rsp_hit == exp_hit, ltag, "rsp_hit", 64'(rsp_hit), 64'(exp_hit));
      chk(rsp_data == exp_d, ltag, "rsp_data", 64'(rsp_data), 64'(exp_d));
    end
    if (fl) begin
      chk(bfill_taken == exp_side, ftag, "bfill_taken", 64'(bfill_taken), 64'(exp_side));
      chk(mfill_valid == !exp_side, ftag, "mfill_valid", 64'(mfill_valid), 64'(!exp_side));
      if (!exp_side) begin
        chk(mfill_addr == fa, ftag, "mfill_addr", 64'(mfill_addr), 64'(fa));
        chk(mfill_data == fd, ftag, "mfill_data", 64'(mfill_data), 64'(fd));
      end
    end else begin
      chk(!mfill_valid && !bfill_taken, ftag, "idle fill outputs",
          64'({mfill_valid, bfill_taken}), 64'd0);
    end
  endtask

  function automatic logic [AW-1:0] pa(input int k);
    return AW'(16'h0400 + k);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = 32'h5EED_0017;
    void'($urandom(seed));
    for (int i = 0; i < NE; i++) begin
      m_val[i] = 1'b0; m_stamp[i] = 0; m_addr[i] = '0; m_data[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(!rsp_valid && !rsp_hit && !mfill_valid && !bfill_taken, "R1", "outputs after reset",
        64'({rsp_valid, rsp_hit, mfill_valid, bfill_taken}), 64'd0);
    chk(rsp_data == '0 && mfill_data == '0, "R1", "data after reset",
        64'(rsp_data | mfill_data), 64'd0);
    for (int k = 0; k < 4; k++) step(1, pa(k), 0, '0, '0, 0, "R1");

    // R3 / R6: refill of a held address overwrites in place
    cfg_mode = 1'b0;
    step(0, '0, 1, pa(0), 32'hAAAA_0001, 0, "R3");
    step(1, pa(0), 1, pa(0), 32'hAAAA_0002, 0, "R6");
    step(1, pa(0), 0, '0, '0, 0, "R6");
    for (int k = 1; k < NE; k++) step(0, '0, 1, pa(k), 32'hB000_0000 + k, 0, "R3");
    for (int k = 0; k < NE; k++) step(1, pa(k), 0, '0, '0, 0, "R6");

    // R8: touch the oldest, then a new line must evict the next oldest
    step(1, pa(0), 0, '0, '0, 0, "R8");
    step(0, '0, 1, pa(20), 32'hC000_0020, 0, "R8");
    step(1, pa(1), 0, '0, '0, 0, "R8");
    step(1, pa(0), 0, '0, '0, 0, "R8");
    step(1, pa(20), 0, '0, '0, 0, "R8");
    // R8: lookup hit and write in the same cycle, only the write counts
    step(1, pa(2), 1, pa(21), 32'hC000_0021, 0, "R8");
    step(1, pa(3), 0, '0, '0, 0, "R8");
    step(1, pa(2), 0, '0, '0, 0, "R8");

    // R2 / R7: high-confidence fill of a buffered address removes the copy
    step(0, '0, 1, pa(5), 32'hD000_0005, 1, "R7");
    step(1, pa(5), 0, '0, '0, 0, "R7");

    // R9: lookup colliding with a fill sees the old state
    step(1, pa(22), 1, pa(22), 32'hE000_0022, 0, "R9");
    step(1, pa(22), 0, '0, '0, 0, "R9");

    // confidence mode, random stimulus
    for (int n = 0; n < 400; n++)
      step($urandom_range(0, 1), pa($urandom_range(0, 27)), $urandom_range(0, 1),
           pa($urandom_range(0, 27)), $urandom, $urandom_range(0, 1), "R5");

    // R4: random mode at fractions 0, 255 and in between; confidence varied
    cfg_mode = 1'b1;
    cfg_frac = 8'd0;
    for (int n = 0; n < 40; n++)
      step(0, '0, 1, pa($urandom_range(0, 27)), $urandom, $urandom_range(0, 1), "R4");
    cfg_frac = 8'd255;
    for (int n = 0; n < 60; n++)
      step(1, pa($urandom_range(0, 27)), 1, pa($urandom_range(0, 27)), $urandom,
           $urandom_range(0, 1), "R4");
    cfg_frac = 8'd51;
    for (int n = 0; n < 600; n++)
      step($urandom_range(0, 1), pa($urandom_range(0, 27)), $urandom_range(0, 1),
           pa($urandom_range(0, 27)), $urandom, $urandom_range(0, 1), "R4");
    // R4: generator holds while in confidence mode
    cfg_mode = 1'b0;
    for (int n = 0; n < 20; n++)
      step(0, '0, 1, pa($urandom_range(0, 27)), $urandom, $urandom_range(0, 1), "R4");
    cfg_mode = 1'b1;
    cfg_frac = 8'd128;
    for (int n = 0; n < 200; n++)
      step($urandom_range(0, 1), pa($urandom_range(0, 27)), 1,
           pa($urandom_range(0, 27)), $urandom, $urandom_range(0, 1), "R4");

    finish_run();
  end
endmodule